// File: doc/BRIEF.md
# SDRAM Read Latency and Data-Mask Pipeline

This block sits on the controller side of an 8-bit single-data-rate synchronous DRAM interface. It follows the column commands that a separate command sequencer issues and works out, cycle by cycle, when read data arrives on the shared data bus. It tells the read consumer which cycles carry a real beat. Writes pass through it so that the write mask and the bus output enable are applied in the correct cycle. It also reports when the bus has turned around far enough for a write to be issued.

Cycles are numbered as follows. A command presented in cycle 0 is taken at the rising edge that ends cycle 0. A latency of N means the matching data is on the bus during cycle N. Each read starts a burst whose beats are issued one per cycle. A new read, a write or a precharge ends the burst that is running. The data mask acts on reads two cycles late and on writes in the same cycle. A low clock enable freezes the block for one edge, and that edge comes one cycle later.

Read data leaves as a valid-only stream. The memory cannot be stalled, so there is no ready signal and no back-pressure: the consumer must accept every cycle in which `rd_valid_o` is high. Latency and burst length are plain mode inputs.

Top module: `sdr_rdlat_pipe`

## Requirements
- R1: `cas_lat_i` holds the latency directly, and only the values 1, 2 and 3 are legal. With burst length 1, a read in cycle 0 gives `rd_valid_o` high in cycle `cas_lat_i` only, and in that cycle `rd_data_o` equals `dq_in_i`.
- R2: `burst_sel_i` encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. A read with no later command gives that many valid beats in consecutive cycles, starting in cycle `cas_lat_i`.
- R3: `dqm_i` high in cycle c drops the read beat that would be valid in cycle c+2. `rd_valid_o` is low in that cycle and `rd_data_o` reads 0. The other beats of the burst are unaffected.
- R4: In any cycle of an accepted write, `dq_oe_o` is high and `dq_out_o` equals `wdata_i`. `wr_en_o` is high in that same cycle only when `dqm_i` is low.
- R5: A precharge in cycle p ends the running burst. Beats issued before it still arrive, and no read beat is valid in cycle p + `cas_lat_i` or later.
- R6: `wr_ok_o` is low while any accepted read beat has not yet reached the bus, in every cycle that carries a read beat, and in the cycle after the last such beat. It is high again from the second cycle after the last beat.
- R7: Read commands may be given in back-to-back cycles. A read that arrives during a burst cuts the old burst and starts a full new burst of its own.
- R8: `cke_i` low in cycle c makes the edge at the end of cycle c+1 have no effect. Outputs in cycle c+2 equal those in cycle c+1. Any command in cycle c+1 is dropped, and `wr_en_o` and `dq_oe_o` stay low in that cycle.
- R9: After reset, `rd_valid_o`, `wr_en_o` and `dq_oe_o` are low and `wr_ok_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable; low freezes the next edge |
| cas_lat_i | input | 2 | Read latency in cycles (1 to 3) |
| burst_sel_i | input | 2 | Burst length select (1, 2, 4, 8 beats) |
| rd_cmd_i | input | 1 | Read column command this cycle |
| wr_cmd_i | input | 1 | Write column command this cycle |
| pre_cmd_i | input | 1 | Precharge command this cycle |
| dqm_i | input | 1 | Data mask |
| dq_in_i | input | 8 | Data sampled from the memory bus |
| wdata_i | input | 8 | Write data from the command side |
| rd_valid_o | output | 1 | Read beat valid this cycle |
| rd_data_o | output | 8 | Read beat data (0 when not valid) |
| wr_en_o | output | 1 | Write byte accepted, not masked |
| dq_oe_o | output | 1 | Controller drives the data bus |
| dq_out_o | output | 8 | Data driven onto the bus |
| wr_ok_o | output | 1 | Bus turnaround done, a write may be issued |

## Verification
The assertions take three things about the inputs as given. The latency value is never 0 and is held steady while any read beat is in flight. At most one of read, write and precharge is high in a cycle. A write is given only while `wr_ok_o` is high. The directed stimulus changes latency only after several idle cycles, never overlaps column commands, and issues writes only when no read is in flight. Within those limits, the assertions cover the write mask, the bus turnaround gap, burst ending on precharge and the output hold during a frozen edge.

// File: rtl/sdr_pipe_pkg.sv
package sdr_pipe_pkg;

  typedef enum logic [1:0] {
    BL_1 = 2'd0,
    BL_2 = 2'd1,
    BL_4 = 2'd2,
    BL_8 = 2'd3
  } burst_len_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic pre;
  } col_cmd_t;

  function automatic int unsigned beats_of(burst_len_e b);
    return 32'd1 << b;
  endfunction

endpackage

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen
  import sdr_pipe_pkg::*;
#(
  parameter int MAX_BL = 8,
  localparam int CNT_W = $clog2(MAX_BL)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  col_cmd_t   cmd_i,
  input  burst_len_e bl_i,
  output logic       beat_o,
  output logic       more_o
);

  logic [CNT_W-1:0] remain_q;

  assign more_o = (remain_q != '0);
  assign beat_o = en_i & (cmd_i.rd | (more_o & ~cmd_i.wr & ~cmd_i.pre));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (en_i) begin
      if (cmd_i.rd)
        remain_q <= CNT_W'(beats_of(bl_i) - 1);
      else if (cmd_i.wr | cmd_i.pre)
        remain_q <= '0;
      else if (more_o)
        remain_q <= remain_q - 1'b1;
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_i.rd, cmd_i.wr, cmd_i.pre})); // R7

  AST_PRE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cmd_i.pre) |=> (remain_q == '0)); // R5

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2,
  localparam int CL_W    = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            beat_i,
  input  logic            dqm_i,
  input  logic [CL_W-1:0] cl_i,
  output logic            out_beat_o,
  output logic            out_valid_o,
  output logic            pending_o,
  output logic            any_o
);

  logic [MAX_CL-1:0]   slot_q;
  logic [MASK_LAT-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q[0] <= 1'b0;
    else if (en_i) slot_q[0] <= beat_i;
  end

  for (genvar k = 1; k < MAX_CL; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[k] <= 1'b0;
      else if (en_i) slot_q[k] <= slot_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q[0] <= 1'b0;
    else if (en_i) mask_q[0] <= dqm_i;
  end

  for (genvar m = 1; m < MASK_LAT; m++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q[m] <= 1'b0;
      else if (en_i) mask_q[m] <= mask_q[m-1];
    end
  end

  always_comb begin
    out_beat_o = 1'b0;
    pending_o  = 1'b0;
    for (int k = 0; k < MAX_CL; k++) begin
      if (cl_i == CL_W'(k + 1)) out_beat_o = slot_q[k];
      if (CL_W'(k + 1) < cl_i)  pending_o  = pending_o | slot_q[k];
    end
  end

  assign out_valid_o = out_beat_o & ~mask_q[MASK_LAT-1];
  assign any_o       = |slot_q;

  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_i != '0) && (cl_i <= CL_W'(MAX_CL))); // R1

endmodule

// File: rtl/sdr_turnaround.sv
module sdr_turnaround (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic out_beat_i,
  input  logic pending_i,
  input  logic more_i,
  output logic wr_ok_o
);

  logic busy_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_prev_q <= 1'b0;
    else if (en_i) busy_prev_q <= out_beat_i;
  end

  assign wr_ok_o = ~(out_beat_i | busy_prev_q | pending_i | more_i);

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && out_beat_i) |=> !wr_ok_o); // R6

endmodule

// File: rtl/sdr_rdlat_pipe.sv
module sdr_rdlat_pipe
  import sdr_pipe_pkg::*;
#(
  parameter int DQ_W     = 8,
  parameter int MAX_CL   = 3,
  parameter int MAX_BL   = 8,
  parameter int MASK_LAT = 2,
  localparam int CL_W    = $clog2(MAX_CL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke_i,
  input  logic [CL_W-1:0] cas_lat_i,
  input  logic [1:0]      burst_sel_i,
  input  logic            rd_cmd_i,
  input  logic            wr_cmd_i,
  input  logic            pre_cmd_i,
  input  logic            dqm_i,
  input  logic [DQ_W-1:0] dq_in_i,
  input  logic [DQ_W-1:0] wdata_i,
  output logic            rd_valid_o,
  output logic [DQ_W-1:0] rd_data_o,
  output logic            wr_en_o,
  output logic            dq_oe_o,
  output logic [DQ_W-1:0] dq_out_o,
  output logic            wr_ok_o
);

  logic     en_q;
  col_cmd_t cmd;
  logic     beat, more, out_beat, pending, any_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= cke_i;
  end

  assign cmd = '{rd: rd_cmd_i, wr: wr_cmd_i, pre: pre_cmd_i};

  sdr_burst_gen #(.MAX_BL(MAX_BL)) u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_q),
    .cmd_i  (cmd),
    .bl_i   (burst_len_e'(burst_sel_i)),
    .beat_o (beat),
    .more_o (more)
  );

  sdr_lat_pipe #(.MAX_CL(MAX_CL), .MASK_LAT(MASK_LAT)) u_lat (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_q),
    .beat_i      (beat),
    .dqm_i       (dqm_i),
    .cl_i        (cas_lat_i),
    .out_beat_o  (out_beat),
    .out_valid_o (rd_valid_o),
    .pending_o   (pending),
    .any_o       (any_slot)
  );

  sdr_turnaround u_turn (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_q),
    .out_beat_i (out_beat),
    .pending_i  (pending),
    .more_i     (more),
    .wr_ok_o    (wr_ok_o)
  );

  assign rd_data_o = rd_valid_o ? dq_in_i : '0;
  assign dq_oe_o   = en_q & wr_cmd_i;
  assign wr_en_o   = dq_oe_o & ~dqm_i;
  assign dq_out_o  = wdata_i;

  AST_CL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_slot || more) |-> $stable(cas_lat_i)); // R1

  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dqm_i |-> !wr_en_o); // R4

  AST_NO_WR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !wr_ok_o); // R6

  AST_WR_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_i && en_q) |-> wr_ok_o); // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(rd_valid_o)); // R8

endmodule

// File: tb/sdr_rdlat_pipe_bench.sv
module sdr_rdlat_pipe_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke_i = 1'b1;
  logic [1:0] cas_lat_i = 2'd1;
  logic [1:0] burst_sel_i = 2'd0;
  logic       rd_cmd_i = 1'b0, wr_cmd_i = 1'b0, pre_cmd_i = 1'b0, dqm_i = 1'b0;
  logic [7:0] dq_in_i = 8'h00, wdata_i = 8'h00;
  logic       rd_valid_o, wr_en_o, dq_oe_o, wr_ok_o;
  logic [7:0] rd_data_o, dq_out_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] g_rv, g_ok, g_we, g_oe;
  logic [7:0]  g_dat [16];
  logic [7:0]  g_wd  [16];

  always #2 clk = ~clk;

  sdr_rdlat_pipe u_sdr_rdlat_pipe (
    .clk(clk), .rst_n(rst_n), .cke_i(cke_i), .cas_lat_i(cas_lat_i),
    .burst_sel_i(burst_sel_i), .rd_cmd_i(rd_cmd_i), .wr_cmd_i(wr_cmd_i),
    .pre_cmd_i(pre_cmd_i), .dqm_i(dqm_i), .dq_in_i(dq_in_i), .wdata_i(wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .wr_en_o(wr_en_o),
    .dq_oe_o(dq_oe_o), .dq_out_o(dq_out_o), .wr_ok_o(wr_ok_o)
  );

  task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Drives one command pattern, cycle i from bit i; ckl marks cke low.
  task automatic run(logic [15:0] rdv, logic [15:0] wrv, logic [15:0] prv,
                     logic [15:0] dmv, logic [15:0] ckl);
    for (int i = 0; i < 16; i++) begin
      rd_cmd_i  = rdv[i];
      wr_cmd_i  = wrv[i];
      pre_cmd_i = prv[i];
      dqm_i     = dmv[i];
      cke_i     = ~ckl[i];
      dq_in_i   = 8'(i + 160);
      wdata_i   = 8'(i);
      @(negedge clk);
      g_rv[i]  = rd_valid_o;
      g_ok[i]  = wr_ok_o;
      g_we[i]  = wr_en_o;
      g_oe[i]  = dq_oe_o;
      g_dat[i] = rd_data_o;
      g_wd[i]  = dq_out_o;
      @(posedge clk);
      #1;
    end
    {rd_cmd_i, wr_cmd_i, pre_cmd_i, dqm_i} = '0;
    cke_i = 1'b1;
    idle(6);
  endtask

  task automatic set_mode(logic [1:0] cl, logic [1:0] bl);
    cas_lat_i   = cl;
    burst_sel_i = bl;
    idle(2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9", "rd_valid", {15'd0, rd_valid_o}, 16'd0);
    chk("R9", "wr_en",    {15'd0, wr_en_o},    16'd0);
    chk("R9", "dq_oe",    {15'd0, dq_oe_o},    16'd0);
    chk("R9", "wr_ok",    {15'd0, wr_ok_o},    16'd1);
    @(posedge clk);
    #1;
  endtask

  task automatic t_latency;
    for (int cl = 1; cl <= 3; cl++) begin
      set_mode(2'(cl), 2'd0);
      run(16'h0001, '0, '0, '0, '0);
      chk("R1", $sformatf("valid CL%0d", cl), g_rv, 16'(1 << cl));
      if (cl == 3) chk("R1", "data CL3", {8'd0, g_dat[3]}, 16'h00A3);
      if (cl == 2) chk("R6", "wr_ok CL2", g_ok, 16'hFFF1);
    end
  endtask

  task automatic t_burst;
    set_mode(2'd2, 2'd2);
    run(16'h0001, '0, '0, '0, '0);
    chk("R2", "burst4 CL2", g_rv, 16'h003C);
    chk("R6", "wr_ok burst4", g_ok, 16'hFF81);
  endtask

  task automatic t_rd_mask;
    set_mode(2'd2, 2'd2);
    run(16'h0001, '0, '0, 16'h0002, '0);
    chk("R3", "masked beat", g_rv, 16'h0034);
    chk("R3", "masked data", {8'd0, g_dat[3]}, 16'h0000);
  endtask

  task automatic t_write;
    set_mode(2'd1, 2'd0);
    run('0, 16'h0007, '0, 16'h0002, '0);
    chk("R4", "wr_en", g_we, 16'h0005);
    chk("R4", "dq_oe", g_oe, 16'h0007);
    chk("R4", "dq_out", {8'd0, g_wd[2]}, 16'h0002);
  endtask

  task automatic t_precharge;
    set_mode(2'd3, 2'd3);
    run(16'h0001, '0, 16'h0004, '0, '0);
    chk("R5", "cut by precharge", g_rv, 16'h0018);
  endtask

  task automatic t_back2back;
    set_mode(2'd1, 2'd2);
    run(16'h0005, '0, '0, '0, '0);
    chk("R7", "restart burst", g_rv, 16'h007E);
  endtask

  task automatic t_freeze;
    set_mode(2'd1, 2'd0);
    run(16'h0003, '0, '0, '0, 16'h0001);
    chk("R8", "held beat", g_rv, 16'h0006);
    run('0, 16'h0006, '0, '0, 16'h0001);
    chk("R8", "wr_en frozen", g_we, 16'h0004);
    chk("R8", "dq_oe frozen", g_oe, 16'h0004);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_latency();
    t_burst();
    t_rd_mask();
    t_write();
    t_precharge();
    t_back2back();
    t_freeze();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule